// File: doc/BRIEF.md
# Two-Tier Programmable-Priority Channel Arbiter

This block picks the next channel a multi-channel transfer engine serves. Each channel has a pending flag. The flag is set either by software or by a hardware request line. Which line drives which channel comes from a software-set routing table, so a line's index carries no priority of its own. Software puts every channel in one of two tiers: upper or lower. A pending channel in the upper tier always wins over every lower-tier channel. Inside each tier, software chooses one of two orderings, and each tier chooses on its own. Fixed ordering favours the lowest channel index. Rotating ordering is a round-robin that starts from channel 0 after reset.

Decisions are registered. A grant is held, unchanged, until the engine pulses `take_grant`. The block then makes a new decision on that same clock edge. A tier's rotation pointer moves only when that tier's grant is taken. A new tier assignment or ordering setting is used at the next decision and leaves a held grant alone.

Top module: `dma_tier_arbiter`

## Requirements
- R1: While `rst_n` is low and after its release with nothing pending, `gnt_valid` is 0 and `gnt_onehot` is all zeros. Both rotation pointers start at channel 0.
- R2: When `gnt_valid` is 1, `gnt_onehot` has exactly bit `gnt_chan` set. A decision made with no pending channel drives `gnt_valid` to 0 and `gnt_onehot` to zero.
- R3: Bit c of `tier_upper` set to 1 puts channel c in the upper tier. Any decision made while an upper-tier channel is pending grants an upper-tier channel.
- R4: With the tier's bit of `tier_rotate` at 0 (fixed), the decision grants the lowest-numbered pending channel of that tier.
- R5: With the tier's bit of `tier_rotate` at 1 (rotating), the search for that tier starts at the channel one above the last taken grant of that tier, modulo NUM_CH. It starts at channel 0 before any grant of that tier has been taken. Bit 0 of `tier_rotate` selects the lower tier and bit 1 the upper tier.
- R6: A tier's rotation pointer changes only when a held grant from that tier is taken. Grants taken from the other tier, and cycles with no take, leave it unchanged.
- R7: Channel c is pending when `sw_req[c]` is 1, or when `route_en[c]` is 1 and the hardware line whose index is stored at `route_line[c*LINE_W +: LINE_W]` is 1. A line's index has no effect on priority.
- R8: While `gnt_valid` is 1 and `take_grant` is 0, `gnt_chan`, `gnt_onehot` and `gnt_valid` keep their values, whatever the requests, tiers or orderings do.
- R9: A decision is made on every clock edge where no grant is held or where `take_grant` is 1. Its result appears after that edge and uses the inputs present at that edge. `take_grant` with no grant held has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_line | input | NUM_LINES | Hardware request lines |
| route_line | input | NUM_CH*LINE_W | Per-channel index of the hardware line that feeds it |
| route_en | input | NUM_CH | Per-channel enable of the hardware route |
| sw_req | input | NUM_CH | Per-channel software request |
| tier_upper | input | NUM_CH | Per-channel tier: 1 upper, 0 lower |
| tier_rotate | input | 2 | Per-tier ordering: bit 0 lower, bit 1 upper; 1 rotating, 0 fixed |
| take_grant | input | 1 | Engine takes the held grant |
| gnt_valid | output | 1 | A grant is held |
| gnt_chan | output | CH_W | Index of the granted channel |
| gnt_onehot | output | NUM_CH | One-hot granted channel |

## Verification
The hardest case to reach from the ports is a rotation pointer that has to survive while the other tier's grants are taken. Both tiers must be in rotating mode. Upper-tier channels must be taken part way round. All upper-tier requests must then drop for several lower-tier takes, and then come back. A directed sequence builds exactly this pattern. A long random run with a fixed seed then keeps changing tier membership, orderings and routes while grants are held, and every cycle is compared with a bench-side model.

// File: rtl/dta_pkg.sv
package dta_pkg;
   typedef enum logic {
      TIER_LOWER = 1'b0,
      TIER_UPPER = 1'b1
   } tier_e;

   localparam int unsigned NUM_TIERS = 2;
endpackage

// File: rtl/dta_req_route.sv
module dta_req_route #(
   parameter int unsigned NUM_CH    = 8,
   parameter int unsigned NUM_LINES = 16,
   localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int unsigned PAD_N    = 1 << LINE_W
) (
   input  logic [NUM_LINES-1:0]       hw_line,
   input  logic [NUM_CH*LINE_W-1:0]   route_line,
   input  logic [NUM_CH-1:0]          route_en,
   input  logic [NUM_CH-1:0]          sw_req,
   output logic [NUM_CH-1:0]          pending
);
   logic [PAD_N-1:0] line_pad;

   generate
      if (PAD_N > NUM_LINES) begin : g_pad
         assign line_pad = {{(PAD_N-NUM_LINES){1'b0}}, hw_line};
      end else begin : g_nopad
         assign line_pad = hw_line;
      end
   endgenerate

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [LINE_W-1:0] sel;
         assign sel        = route_line[c*LINE_W +: LINE_W];
         assign pending[c] = sw_req[c] | (route_en[c] & line_pad[sel]);
      end
   endgenerate

   always_comb begin
      if (sw_req == '0 && route_en == '0)
         assert_no_source_R7: assert (pending == '0);
   end
endmodule

// File: rtl/dta_tier_pick.sv
module dta_tier_pick #(
   parameter int unsigned NUM_CH       = 8,
   parameter bit          ALLOW_ROTATE = 1'b1,
   localparam int unsigned CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cand,
   input  logic              rotate,
   input  logic              adv,
   input  logic [CH_W-1:0]   adv_chan,
   output logic              hit,
   output logic [CH_W-1:0]   pick
);
   function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] v);
      logic [CH_W-1:0] r;
      r = '0;
      for (int i = NUM_CH - 1; i >= 0; i--)
         if (v[i]) r = CH_W'(i);
      return r;
   endfunction

   logic [CH_W-1:0]   ptr_q;
   logic [CH_W-1:0]   eff_ptr;
   logic [NUM_CH-1:0] upper_mask;
   logic [NUM_CH-1:0] cand_up;

   assign hit = |cand;

   generate
      if (ALLOW_ROTATE) begin : g_rot
         logic [CH_W-1:0] step_ptr;
         assign step_ptr = (adv_chan == CH_W'(NUM_CH - 1)) ? '0 : adv_chan + 1'b1;
         assign eff_ptr  = adv ? step_ptr : ptr_q;

         always_ff @(posedge clk) begin
            if (!rst_n)   ptr_q <= '0;
            else if (adv) ptr_q <= step_ptr;
         end

         for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
            assign upper_mask[i] = (CH_W'(i) >= eff_ptr);
         end
         assign cand_up = cand & upper_mask;

         always_comb begin
            if (rotate && (cand_up != '0)) pick = lowest_set(cand_up);
            else                           pick = lowest_set(cand);
         end

         assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !adv |=> $stable(ptr_q));
      end else begin : g_fixed
         assign ptr_q      = '0;
         assign eff_ptr    = '0;
         assign upper_mask = '1;
         assign cand_up    = cand;
         assign pick       = lowest_set(cand);
      end
   endgenerate

   assert_fixed_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !rotate) |-> ((cand & ((NUM_CH'(1) << pick) - 1'b1)) == '0));
   assert_pick_in_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> cand[pick]);
endmodule

// File: rtl/dma_tier_arbiter.sv
module dma_tier_arbiter
   import dta_pkg::*;
#(
   parameter int unsigned NUM_CH       = 8,
   parameter int unsigned NUM_LINES    = 16,
   parameter bit          ALLOW_ROTATE = 1'b1,
   localparam int unsigned CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int unsigned LINE_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_LINES-1:0]      hw_line,
   input  logic [NUM_CH*LINE_W-1:0]  route_line,
   input  logic [NUM_CH-1:0]         route_en,
   input  logic [NUM_CH-1:0]         sw_req,
   input  logic [NUM_CH-1:0]         tier_upper,
   input  logic [1:0]                tier_rotate,
   input  logic                      take_grant,
   output logic                      gnt_valid,
   output logic [CH_W-1:0]           gnt_chan,
   output logic [NUM_CH-1:0]         gnt_onehot
);
   generate
      if (NUM_CH < 2)    begin : g_bad_ch   $error("NUM_CH must be at least 2");    end
      if (NUM_LINES < 1) begin : g_bad_line $error("NUM_LINES must be at least 1"); end
   endgenerate

   logic [NUM_CH-1:0] pending;
   logic [NUM_CH-1:0] cand   [NUM_TIERS];
   logic              hit    [NUM_TIERS];
   logic [CH_W-1:0]   pick   [NUM_TIERS];
   logic              adv    [NUM_TIERS];

   logic              held_q;
   logic [CH_W-1:0]   chan_q;
   tier_e             tier_q;
   logic              decide;
   logic              taken;

   dta_req_route #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_route (
      .hw_line    (hw_line),
      .route_line (route_line),
      .route_en   (route_en),
      .sw_req     (sw_req),
      .pending    (pending)
   );

   assign decide = !held_q || take_grant;
   assign taken  = held_q && take_grant;

   generate
      for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
         assign cand[t] = (t == int'(TIER_UPPER)) ? (pending & tier_upper)
                                                  : (pending & ~tier_upper);
         assign adv[t]  = taken && (tier_q == tier_e'(t));

         dta_tier_pick #(.NUM_CH(NUM_CH), .ALLOW_ROTATE(ALLOW_ROTATE)) u_pick (
            .clk      (clk),
            .rst_n    (rst_n),
            .cand     (cand[t]),
            .rotate   (tier_rotate[t]),
            .adv      (adv[t]),
            .adv_chan (chan_q),
            .hit      (hit[t]),
            .pick     (pick[t])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         chan_q <= '0;
         tier_q <= TIER_LOWER;
      end else if (decide) begin
         held_q <= hit[TIER_UPPER] | hit[TIER_LOWER];
         if (hit[TIER_UPPER]) begin
            chan_q <= pick[TIER_UPPER];
            tier_q <= TIER_UPPER;
         end else begin
            chan_q <= pick[TIER_LOWER];
            tier_q <= TIER_LOWER;
         end
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
         assign gnt_onehot[c] = held_q && (chan_q == CH_W'(c));
      end
   endgenerate

   assign gnt_valid = held_q;
   assign gnt_chan  = chan_q;

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !take_grant) |=> (held_q && $stable(chan_q)));
   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && pending == '0) |=> !held_q);
   assert_upper_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && (pending & tier_upper) != '0) |=> (tier_q == TIER_UPPER));
   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_onehot) && (gnt_valid == (gnt_onehot != '0)));
endmodule

// File: tb/dma_tier_arbiter_test.sv
module dma_tier_arbiter_test;
   localparam int NCH = 8;
   localparam int NL  = 16;
   localparam int CW  = 3;
   localparam int LW  = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NL-1:0]     hw_line;
   logic [NCH*LW-1:0] route_line;
   logic [NCH-1:0]    route_en;
   logic [NCH-1:0]    sw_req;
   logic [NCH-1:0]    tier_upper;
   logic [1:0]        tier_rotate;
   logic              take_grant;
   logic              gnt_valid;
   logic [CW-1:0]     gnt_chan;
   logic [NCH-1:0]    gnt_onehot;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   int m_ptr [2];
   bit m_valid;
   int m_chan;
   int m_tier;

   always #5 clk = ~clk;

   dma_tier_arbiter #(.NUM_CH(NCH), .NUM_LINES(NL)) uut (
      .clk(clk), .rst_n(rst_n), .hw_line(hw_line), .route_line(route_line),
      .route_en(route_en), .sw_req(sw_req), .tier_upper(tier_upper),
      .tier_rotate(tier_rotate), .take_grant(take_grant),
      .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .gnt_onehot(gnt_onehot)
   );

   function automatic logic [NCH-1:0] calc_pending();
      logic [NCH-1:0] p;
      for (int c = 0; c < NCH; c++) begin
         int ln;
         ln = int'(route_line[c*LW +: LW]);
         p[c] = sw_req[c] || (route_en[c] && ln < NL && hw_line[ln]);
      end
      return p;
   endfunction

   function automatic int search(logic [NCH-1:0] set, bit rot, int start);
      int s;
      s = rot ? start : 0;
      for (int k = 0; k < NCH; k++)
         if (set[(s + k) % NCH]) return (s + k) % NCH;
      return -1;
   endfunction

   task automatic model_update();
      logic [NCH-1:0] p;
      int w;
      p = calc_pending();
      if (m_valid && take_grant) m_ptr[m_tier] = (m_chan + 1) % NCH;
      if (!m_valid || take_grant) begin
         w = search(p & tier_upper, tier_rotate[1], m_ptr[1]);
         if (w >= 0) begin
            m_valid = 1; m_chan = w; m_tier = 1;
         end else begin
            w = search(p & ~tier_upper, tier_rotate[0], m_ptr[0]);
            m_valid = (w >= 0);
            if (w >= 0) begin m_chan = w; m_tier = 0; end
         end
      end
   endtask

   task automatic compare(string tag);
      logic [NCH-1:0] exp_oh;
      exp_oh = m_valid ? (NCH'(1) << m_chan) : '0;
      n_tests++;
      if (gnt_valid !== m_valid || gnt_onehot !== exp_oh ||
          (m_valid && gnt_chan !== CW'(m_chan))) begin
         n_fail++;
         $display("FAIL %s: valid=%0b chan=%0d onehot=%b expected valid=%0b chan=%0d onehot=%b",
                  tag, gnt_valid, gnt_chan, gnt_onehot, m_valid, m_chan, exp_oh);
      end
   endtask

   task automatic step(string tag);
      model_update();
      @(posedge clk); #1;
      compare(tag);
      @(negedge clk);
   endtask

   task automatic set_route(int ch, int ln, bit en);
      route_line[ch*LW +: LW] = LW'(ln);
      route_en[ch] = en;
   endtask

   initial begin
      rst_n = 0; hw_line = '0; route_line = '0; route_en = '0; sw_req = '0;
      tier_upper = '0; tier_rotate = 2'b00; take_grant = 0;
      m_ptr[0] = 0; m_ptr[1] = 0; m_valid = 0; m_chan = 0; m_tier = 0;
      repeat (3) @(posedge clk);
      #1; compare("R1 reset");
      @(negedge clk); rst_n = 1;
      step("R1 idle after reset");
      step("R2 nothing pending");

      // R4 fixed lowest wins
      sw_req = 8'b1011_0110; step("R4 fixed lowest");
      take_grant = 1; step("R4 fixed after take");
      sw_req = 8'b1011_0000; step("R4 fixed next");
      sw_req = '0; step("R2 drop to idle");
      take_grant = 0;

      // R3 upper beats lower
      tier_upper = 8'b0010_0000; sw_req = 8'b0010_0011; step("R3 upper wins");
      take_grant = 1; sw_req = 8'b1000_0011; tier_upper = 8'b1000_0000; step("R3 upper wins again");
      sw_req = '0; step("R3 to idle"); take_grant = 0; tier_upper = '0;

      // R7 routing
      set_route(3, 9, 1); hw_line[9] = 1; step("R7 routed line");
      take_grant = 1; set_route(3, 9, 0); step("R7 disabled route ignored");
      hw_line = '0; hw_line[0] = 1; hw_line[15] = 1;
      set_route(6, 0, 1); set_route(2, 15, 1); step("R7 line index no priority");
      hw_line = '0; route_en = '0; step("R7 to idle"); take_grant = 0;

      // R9 take without grant ignored
      take_grant = 1; step("R9 take while idle"); take_grant = 0;

      // R5 rotating lower tier
      tier_rotate = 2'b01; sw_req = 8'hFF;
      step("R5 rotate start at 0");
      take_grant = 1;
      for (int i = 0; i < 10; i++) step("R5 rotate sequence");
      sw_req = 8'b0001_0001; step("R5 rotate wrap");
      step("R5 rotate wrap 2");
      sw_req = '0; step("R5 idle"); take_grant = 0;

      // R6 pointer isolation between tiers
      tier_rotate = 2'b11; tier_upper = 8'h0F; sw_req = 8'hFF; take_grant = 1;
      for (int i = 0; i < 3; i++) step("R6 upper rotate");
      sw_req = 8'hF0;
      for (int i = 0; i < 5; i++) step("R6 lower while upper idle");
      sw_req = 8'hFF;
      for (int i = 0; i < 3; i++) step("R6 upper resumes");
      take_grant = 0;

      // R8 hold while inputs move
      sw_req = 8'h00; step("R8 hold with requests gone");
      tier_upper = 8'hF0; tier_rotate = 2'b00; sw_req = 8'h01; step("R8 hold with config change");
      hw_line = '1; route_en = '1; step("R8 hold with lines");
      take_grant = 1; hw_line = '0; route_en = '0; step("R9 config used at next decision");
      take_grant = 0; sw_req = '0;

      // random phase
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 3000; i++) begin
         sw_req      = NCH'($urandom) & NCH'($urandom);
         hw_line     = NL'($urandom) & NL'($urandom);
         route_en    = NCH'($urandom);
         route_line  = {$urandom, $urandom};
         if ($urandom_range(0, 7) == 0) tier_upper  = NCH'($urandom);
         if ($urandom_range(0, 15) == 0) tier_rotate = 2'($urandom);
         take_grant  = ($urandom_range(0, 3) != 0);
         step("R9 random");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule